// File: doc/BRIEF.md
# Byte-Serial Bus Listener Acceptor

This block is the receiving end of a three-wire interlocked byte handshake on a shared parallel instrument bus. The talker lowers an active-low strobe when a byte is on the eight data lines. Every listener then contributes to two wired-OR lines: a busy line, which holds off the next byte, and a wait line, which the talker reads as "byte not yet taken". The shared wait line rises only when every listener has released it. The slowest listener therefore sets the pace for the whole bus. The block drives its own pull-down requests for both lines. A pull request of 1 means the line is driven low; 0 means the line is released.

Each accepted byte is latched together with two flags. The attention level marks the byte as a command or address rather than device data. The end flag marks the last byte of a record. The byte and its flags go into a small buffer. The buffer is drained through a valid/ready port on the local side. While that buffer is full, the block keeps the busy line pulled low, so local backpressure reaches the talker. An interface-clear input aborts any handshake in progress and returns the acceptor to idle.

The strobe and clear inputs pass through a `SYNC_STAGES`-deep synchronizer. Data, attention and end are sampled directly, one clock after the synchronized strobe shows valid. The talker holds these lines steady for the whole valid phase.

Top module: `bus_listener`

## Requirements
- R1: While and after reset, and before any strobe, `wait_pull_o` is 1, `busy_pull_o` is 0 and `out_valid_o` is 0.
- R2: `SYNC_STAGES`+1 clocks after `bus_strobe_ni` falls, `busy_pull_o` becomes 1. `wait_pull_o` stays 1 for two more clocks and drops to 0 at `SYNC_STAGES`+3 clocks. `wait_pull_o` never drops unless `busy_pull_o` was already 1 in the previous cycle.
- R3: In the same clock that `wait_pull_o` drops (the buffer being empty beforehand), `out_valid_o` becomes 1 and `out_data_o` equals the byte on `bus_data_i`.
- R4: `out_cmd_o` equals the level of `bus_cmd_i` (1 = attention true, command/address byte) at the moment of capture.
- R5: `out_end_o` equals the level of `bus_end_i` (1 = last byte of a record) at the moment of capture.
- R6: `SYNC_STAGES`+1 clocks after `bus_strobe_ni` rises, `wait_pull_o` returns to 1 while `busy_pull_o` is still 1. `busy_pull_o` is released one clock later if the buffer has room. Outside a clear, `busy_pull_o` never falls unless `wait_pull_o` was 1 in the previous cycle.
- R7: `wait_pull_o` is 0 only while `busy_pull_o` is 1.
- R8: While the buffer holds `DEPTH` bytes, `busy_pull_o` stays 1 and a pending strobe is not accepted. Once a byte is drained, the pending transfer completes.
- R9: `SYNC_STAGES`+1 clocks after `bus_clear_i` rises, `wait_pull_o` is 1. A strobe seen while clear is active is never accepted or delivered.
- R10: While `out_valid_o` is 1 and `out_ready_i` is 0, the output byte and its flags hold steady. Bytes leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_data_i | input | 8 | Bus data lines (logical value) |
| bus_strobe_ni | input | 1 | Talker data-valid strobe, low = valid |
| bus_cmd_i | input | 1 | Attention level, 1 = byte is command/address |
| bus_end_i | input | 1 | End-of-record flag |
| bus_clear_i | input | 1 | Interface clear, 1 = return to idle |
| busy_pull_o | output | 1 | 1 = pull not-ready line low |
| wait_pull_o | output | 1 | 1 = pull not-accepted line low |
| out_valid_o | output | 1 | Local byte available |
| out_ready_i | input | 1 | Local consumer takes the byte |
| out_data_o | output | 8 | Received byte |
| out_cmd_o | output | 1 | Byte was received as command/address |
| out_end_o | output | 1 | Byte ends a record |

## Verification
The bench drives inputs on the falling clock edge and counts rising edges from each stimulus. With two synchronizer stages, `busy_pull_o` is due on the third edge after the strobe falls, and the release of `wait_pull_o` together with the delivered byte is due on the fifth. The return of `wait_pull_o` is due on the third edge after the strobe rises, and the release of `busy_pull_o` on the fourth. A clear takes effect on the third edge after it is raised. Each check samples at the falling edge that follows the edge on which the result is due, and the intermediate falling edges are also checked to confirm the line has not moved early.

// File: rtl/bl_pkg.sv
`timescale 1ns/1ps
package bl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETTLE  = 3'd1,
    ST_CAPTURE = 3'd2,
    ST_ACCEPT  = 3'd3,
    ST_RECOVER = 3'd4
  } hs_state_e;

  typedef struct packed {
    logic              cmd;
    logic              last;
    logic [BYTE_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/bl_sync.sv
`timescale 1ns/1ps
module bl_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= INIT;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= INIT;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bl_handshake.sv
`timescale 1ns/1ps
module bl_handshake
  import bl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_s_i,
  input  logic clear_s_i,
  input  logic space_i,
  output logic busy_pull_o,
  output logic wait_pull_o,
  output logic capture_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (valid_s_i && space_i) state_d = ST_SETTLE;
      ST_SETTLE:  state_d = ST_CAPTURE;   // one clock for data lines to settle
      ST_CAPTURE: state_d = ST_ACCEPT;
      ST_ACCEPT:  if (!valid_s_i) state_d = ST_RECOVER;
      ST_RECOVER: state_d = ST_IDLE;      // wait line re-pulled before busy release
      default:    state_d = ST_IDLE;
    endcase
    if (clear_s_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_pull_o = (state_q != ST_IDLE) || !space_i;
  assign wait_pull_o = (state_q != ST_ACCEPT);
  assign capture_o   = (state_q == ST_CAPTURE) && !clear_s_i;
endmodule

// File: rtl/bl_outbuf.sv
`timescale 1ns/1ps
module bl_outbuf
  import bl_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  rx_word_t          push_word_i,
  input  logic              pop_ready_i,
  output logic              out_valid_o,
  output rx_word_t          out_word_o,
  output logic              space_o,
  output logic [FILL_W-1:0] fill_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rx_word_t          mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [FILL_W-1:0] fill_q;
  logic              pop;

  assign out_valid_o = (fill_q != '0);
  assign pop         = out_valid_o && pop_ready_i;
  assign space_o     = (fill_q < FILL_W'(DEPTH));
  assign fill_o      = fill_q;
  assign out_word_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[e] <= '0;
      else if (push_i && wr_q == PTR_W'(e))    mem_q[e] <= push_word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop)    rd_q <= ptr_inc(rd_q);
      unique case ({push_i, pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end
endmodule

// File: rtl/bus_listener.sv
`timescale 1ns/1ps
module bus_listener
  import bl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEPTH       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] bus_data_i,
  input  logic              bus_strobe_ni,
  input  logic              bus_cmd_i,
  input  logic              bus_end_i,
  input  logic              bus_clear_i,
  output logic              busy_pull_o,
  output logic              wait_pull_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_cmd_o,
  output logic              out_end_o
);
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [1:0]        sync_q;
  logic              valid_s, clear_s, space, capture;
  logic [FILL_W-1:0] fill_w;
  rx_word_t          in_word, head_word;

  bl_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({bus_strobe_ni, bus_clear_i}),
    .q_o    (sync_q)
  );

  assign valid_s = !sync_q[1];
  assign clear_s = sync_q[0];

  bl_handshake u_hs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_s_i   (valid_s),
    .clear_s_i   (clear_s),
    .space_i     (space),
    .busy_pull_o (busy_pull_o),
    .wait_pull_o (wait_pull_o),
    .capture_o   (capture)
  );

  assign in_word = '{cmd: bus_cmd_i, last: bus_end_i, data: bus_data_i};

  bl_outbuf #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (capture),
    .push_word_i (in_word),
    .pop_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_word_o  (head_word),
    .space_o     (space),
    .fill_o      (fill_w)
  );

  assign out_data_o = head_word.data;
  assign out_cmd_o  = head_word.cmd;
  assign out_end_o  = head_word.last;
endmodule

// File: rtl/bus_listener_chk.sv
`timescale 1ns/1ps
module bus_listener_chk #(
  parameter int DEPTH  = 2,
  parameter int FILL_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_pull_o,
  input logic              wait_pull_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [7:0]        out_data_o,
  input logic              out_cmd_o,
  input logic              out_end_o,
  input logic              clear_s_i,
  input logic              push_i,
  input logic [FILL_W-1:0] fill_i
);
  // R7
  release_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_pull_o |-> busy_pull_o);

  // R2
  busy_before_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wait_pull_o) |-> busy_pull_o && $past(busy_pull_o));

  // R6
  wait_before_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_pull_o) |-> wait_pull_o && ($past(wait_pull_o) || clear_s_i));

  // R8
  full_holds_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i == FILL_W'(DEPTH)) |-> busy_pull_o);

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (fill_i < FILL_W'(DEPTH)));

  // R10
  hold_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_cmd_o) && $stable(out_end_o));
endmodule

bind bus_listener bus_listener_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_pull_o (busy_pull_o),
  .wait_pull_o (wait_pull_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_cmd_o   (out_cmd_o),
  .out_end_o   (out_end_o),
  .clear_s_i   (clear_s),
  .push_i      (capture),
  .fill_i      (fill_w)
);

// File: tb/bus_listener_test.sv
`timescale 1ns/1ps
module bus_listener_test;
  localparam int SYNC = 2;
  localparam int DEP  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_data = '0;
  logic       strobe_n = 1'b1, bus_cmd = 1'b0, bus_end = 1'b0, clear = 1'b0;
  logic       out_ready = 1'b1;
  logic       busy_pull, wait_pull, out_valid, out_cmd, out_end;
  logic [7:0] out_data;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bus_listener #(.SYNC_STAGES(SYNC), .DEPTH(DEP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_data_i(bus_data), .bus_strobe_ni(strobe_n),
    .bus_cmd_i(bus_cmd), .bus_end_i(bus_end), .bus_clear_i(clear),
    .busy_pull_o(busy_pull), .wait_pull_o(wait_pull), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .out_cmd_o(out_cmd), .out_end_o(out_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Full interlocked transfer; inputs change on a falling edge, counted from there.
  task automatic xfer(input logic [7:0] d, input logic c, input logic l,
                      input bit chk_head, input bit end_busy);
    bus_data = d; bus_cmd = c; bus_end = l; strobe_n = 1'b0;
    tick(SYNC);
    eq("R2 busy early", busy_pull, 0);
    tick(1);
    eq("R2 busy at sync+1", busy_pull, 1);
    eq("R2 wait held", wait_pull, 1);
    tick(1);
    eq("R2 wait held sync+2", wait_pull, 1);
    tick(1);
    eq("R2 wait released sync+3", wait_pull, 0);
    if (chk_head) begin
      eq("R3 valid", out_valid, 1);
      eq("R3 data", out_data, d);
      eq("R4 cmd tag", out_cmd, c);
      eq("R5 end tag", out_end, l);
    end
    strobe_n = 1'b1;
    tick(SYNC);
    eq("R6 wait still released", wait_pull, 0);
    tick(1);
    eq("R6 wait re-pulled", wait_pull, 1);
    eq("R6 busy still held", busy_pull, 1);
    tick(1);
    eq("R6 busy after return", busy_pull, end_busy);
  endtask

  initial begin
    tick(3);
    eq("R1 wait in reset", wait_pull, 1);
    eq("R1 busy in reset", busy_pull, 0);
    rst_n = 1'b1;
    tick(2);
    eq("R1 wait idle", wait_pull, 1);
    eq("R1 busy idle", busy_pull, 0);
    eq("R1 no output", out_valid, 0);

    // Sweep every byte value with all four tag combinations in rotation.
    for (int v = 0; v < 256; v++) begin
      xfer(8'(v), v[0], v[1], 1'b1, 1'b0);
      tick(1);
      eq("R3 byte drained", out_valid, 0);
    end

    // Backpressure: fill DEPTH entries with consumer stalled.
    out_ready = 1'b0;
    xfer(8'hA1, 1'b0, 1'b0, 1'b1, 1'b0);
    xfer(8'hB2, 1'b1, 1'b0, 1'b0, 1'b1);
    eq("R8 busy held while full", busy_pull, 1);
    bus_data = 8'hC3; bus_cmd = 1'b0; bus_end = 1'b1; strobe_n = 1'b0;
    tick(12);
    eq("R8 not accepted while full", wait_pull, 1);
    eq("R8 busy while full", busy_pull, 1);
    eq("R10 head held", out_data, 8'hA1);
    eq("R10 head cmd held", out_cmd, 0);
    out_ready = 1'b1;
    tick(1);
    eq("R10 order second", out_data, 8'hB2);
    eq("R10 second cmd", out_cmd, 1);
    begin
      int n = 0;
      while (wait_pull && n < 12) begin tick(1); n++; end
      eq("R8 resumes after drain", wait_pull, 0);
      eq("R8 pending byte valid", out_valid, 1);
      eq("R10 order third", out_data, 8'hC3);
      eq("R5 third end tag", out_end, 1);
    end
    strobe_n = 1'b1;
    tick(SYNC + 3);
    eq("R8 idle after drain", busy_pull, 0);
    eq("R6 wait idle", wait_pull, 1);

    // Clear raised together with strobe: nothing accepted.
    bus_data = 8'h5A; strobe_n = 1'b0; clear = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      eq("R9 wait held under clear", wait_pull, 1);
      eq("R9 nothing delivered", out_valid, 0);
    end
    strobe_n = 1'b1;
    tick(4);
    clear = 1'b0;
    tick(4);
    eq("R9 idle busy", busy_pull, 0);

    // Clear in the accept phase.
    bus_data = 8'h3C; strobe_n = 1'b0;
    tick(SYNC + 3);
    eq("R3 accept before clear", wait_pull, 0);
    clear = 1'b1;
    tick(SYNC);
    eq("R9 not yet cleared", wait_pull, 0);
    tick(1);
    eq("R9 wait re-pulled by clear", wait_pull, 1);
    strobe_n = 1'b1;
    tick(4);
    clear = 1'b0;
    tick(4);
    xfer(8'h96, 1'b1, 1'b1, 1'b1, 1'b0);
    tick(2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule